// File: doc/BRIEF.md
# Seven-Bit SEC-DED Codec for Three Data Bits

This block protects three data bits with four check bits. Three of the check bits follow a distance-3 single-error-correcting code. The fourth is the XOR of all three data bits. With it, every single-bit error produces an odd-weight syndrome and every double-bit error produces an even-weight syndrome, so the two cases never share a code.

The encoder side is combinational. It turns three data bits into a seven-bit word. The decoder side takes a received seven-bit word under a valid strobe and computes a four-bit syndrome. A single sixteen-way one-hot decode sorts that syndrome into one of four classes: clean, single error, double error, or an error of more than two bits. Only a single error in a data position changes the data. The class, the syndrome, the data and an uncorrectable flag are registered, and they appear one clock after the word is accepted.

In a self-check loop, encoder output is XORed with an error mask and fed straight back into the decoder.

Top module: `secded73_codec`

## Requirements
- R1: `enc_word_o` is combinational and equals {D1, D2, D3, C1, C2, C3, C4}, most significant bit first, where `enc_data_i` = {D1, D2, D3} and C1 = D1^D3, C2 = D2^D3, C3 = D1^D2, C4 = D1^D2^D3.
- R2: For a received word {D1, D2, D3, C1, C2, C3, C4} (bit 6 down to bit 0), `out_syndrome_o` = {S1, S2, S3, S4}, most significant bit first. Here S1 = C1^D1^D3, S2 = C2^D2^D3, S3 = C3^D1^D2 and S4 = C4^D1^D2^D3.
- R3: The class code 2'b00 (clean) is reported exactly when the syndrome is 4'b0000. In that case the data leaves unchanged and `out_uncorr_o` is 0.
- R4: Class 2'b01 (single) is reported for every odd-weight syndrome other than 4'b1110. Syndrome 1011 inverts D1, 0111 inverts D2 and 1101 inverts D3. The codes 1000, 0100, 0010 and 0001 (check-bit errors) leave the data as received. `out_uncorr_o` is 0.
- R5: Class 2'b10 (double) is reported for every nonzero even-weight syndrome. The data passes through unchanged and `out_uncorr_o` is 1.
- R6: Syndrome 4'b1110 gives class 2'b11 (more than two errors). The data passes through unchanged and `out_uncorr_o` is 1.
- R7: A word sampled with `rx_valid_i` high produces its results on the outputs after that clock edge. `out_valid_o` is high for exactly the cycle after each cycle in which `rx_valid_i` was high.
- R8: While `rx_valid_i` is low, the class, syndrome, data and flag outputs keep their previous values, whatever `rx_word_i` carries.
- R9: During and after reset, before any accepted word, all outputs of the decoder side are zero.
- R10: Any codeword with exactly one bit inverted, in any of the seven positions, decodes to class single with the original data. Any codeword with exactly two bits inverted decodes to class double.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | 3 | Data to encode, {D1, D2, D3} |
| enc_word_o | output | 7 | Encoded word |
| rx_valid_i | input | 1 | Received word is present this cycle |
| rx_word_i | input | 7 | Received word, same layout as the encoded word |
| out_valid_o | output | 1 | Results below belong to a newly accepted word |
| out_class_o | output | 2 | Error class: 00 clean, 01 single, 10 double, 11 more than two |
| out_syndrome_o | output | 4 | Syndrome {S1, S2, S3, S4} |
| out_data_o | output | 3 | Data, corrected in the single class only |
| out_uncorr_o | output | 1 | Error detected but not corrected |

## Verification
The bench goes through all eight data values. For each one it applies the clean word, all seven single inversions and all twenty-one double inversions. It then adds random masks of every weight, which reach the 1110 code and the three-error patterns that look like single errors.

Each check catches a specific fault:
- A swapped data column would correct the wrong bit on a single error.
- Treating 1110 as a single error would report class 01 instead of 11.
- Correcting in the double class would corrupt data that should pass through.

Separate directed steps check the hold-while-idle behaviour and the one-cycle strobe. A design that reloads its registers on an idle cycle fails the hold check, and one that stretches the strobe fails the strobe check.

// File: rtl/secded73_pkg.sv
package secded73_pkg;

  localparam int DATA_W  = 3;
  localparam int PAR_W   = 4;
  localparam int WORD_W  = DATA_W + PAR_W;
  localparam int SYN_W   = PAR_W;
  localparam int NUM_SYN = 1 << SYN_W;

  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'b00,
    CLS_SINGLE = 2'b01,
    CLS_DOUBLE = 2'b10,
    CLS_MULTI  = 2'b11
  } err_class_e;

  // Syndrome kept aside to flag errors of more than two bits
  localparam logic [SYN_W-1:0] SYN_MULTI = 4'b1110;

  // d = {D1, D2, D3}; returns {C1, C2, C3, C4}
  function automatic logic [PAR_W-1:0] make_parity(input logic [DATA_W-1:0] d);
    logic [PAR_W-1:0] p;
    p[3] = d[2] ^ d[0];
    p[2] = d[1] ^ d[0];
    p[1] = d[2] ^ d[1];
    p[0] = ^d;
    return p;
  endfunction

  // Recompute check bits from the data field and compare with the received ones
  function automatic logic [SYN_W-1:0] calc_syndrome(input logic [WORD_W-1:0] w);
    return make_parity(w[WORD_W-1 -: DATA_W]) ^ w[PAR_W-1:0];
  endfunction

  function automatic err_class_e class_of(input logic [SYN_W-1:0] s);
    if (s == '0)             return CLS_CLEAN;
    else if (s == SYN_MULTI) return CLS_MULTI;
    else if (^s)             return CLS_SINGLE;
    else                     return CLS_DOUBLE;
  endfunction

endpackage

// File: rtl/secded73_enc.sv
module secded73_enc
  import secded73_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o
);

  logic [PAR_W-1:0] chk_bits;

  assign chk_bits = make_parity(data_i);
  assign word_o   = {data_i, chk_bits};

endmodule

// File: rtl/secded73_syn.sv
module secded73_syn
  import secded73_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [SYN_W-1:0]  syn_o
);

  assign syn_o = calc_syndrome(word_i);

endmodule

// File: rtl/secded73_cls.sv
module secded73_cls
  import secded73_pkg::*;
(
  input  logic [SYN_W-1:0]   syn_i,
  output logic [NUM_SYN-1:0] hot_o,
  output err_class_e         class_o
);

  logic [1:0] contrib [NUM_SYN];

  // One output per syndrome value; each output carries its fixed class code
  for (genvar i = 0; i < NUM_SYN; i++) begin : g_line
    localparam err_class_e LINE_CLASS = class_of(SYN_W'(i));
    assign hot_o[i]   = (syn_i == SYN_W'(i));
    assign contrib[i] = hot_o[i] ? 2'(LINE_CLASS) : 2'b00;
  end

  always_comb begin
    logic [1:0] acc;
    acc = 2'b00;
    for (int k = 0; k < NUM_SYN; k++) acc = acc | contrib[k];
    class_o = err_class_e'(acc);
  end

endmodule

// File: rtl/secded73_fix.sv
module secded73_fix
  import secded73_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [SYN_W-1:0]  syn_i,
  input  err_class_e        class_i,
  output logic [DATA_W-1:0] flip_o,
  output logic [DATA_W-1:0] data_o
);

  // The syndrome of an error on data bit i equals the check bits of a one-hot data word
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [SYN_W-1:0] COLUMN = make_parity(DATA_W'(1 << i));
    assign flip_o[i] = (class_i == CLS_SINGLE) && (syn_i == COLUMN);
  end

  assign data_o = data_i ^ flip_o;

endmodule

// File: rtl/secded73_codec.sv
module secded73_codec
  import secded73_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [WORD_W-1:0] enc_word_o,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              out_valid_o,
  output logic [1:0]        out_class_o,
  output logic [SYN_W-1:0]  out_syndrome_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_uncorr_o
);

  logic [SYN_W-1:0]   rx_syn;
  logic [NUM_SYN-1:0] rx_hot;
  err_class_e         rx_class;
  logic [DATA_W-1:0]  rx_flip;
  logic [DATA_W-1:0]  rx_fixed;
  logic               rx_uncorr;

  secded73_enc u_enc (
    .data_i (enc_data_i),
    .word_o (enc_word_o)
  );

  secded73_syn u_syn (
    .word_i (rx_word_i),
    .syn_o  (rx_syn)
  );

  secded73_cls u_cls (
    .syn_i   (rx_syn),
    .hot_o   (rx_hot),
    .class_o (rx_class)
  );

  secded73_fix u_fix (
    .data_i  (rx_word_i[WORD_W-1 -: DATA_W]),
    .syn_i   (rx_syn),
    .class_i (rx_class),
    .flip_o  (rx_flip),
    .data_o  (rx_fixed)
  );

  assign rx_uncorr = (rx_class == CLS_DOUBLE) || (rx_class == CLS_MULTI);

  logic              valid_q;
  err_class_e        class_q;
  logic [SYN_W-1:0]  syn_q;
  logic [DATA_W-1:0] data_q;
  logic              uncorr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      class_q  <= CLS_CLEAN;
      syn_q    <= '0;
      data_q   <= '0;
      uncorr_q <= 1'b0;
    end else begin
      valid_q <= rx_valid_i;
      if (rx_valid_i) begin
        class_q  <= rx_class;
        syn_q    <= rx_syn;
        data_q   <= rx_fixed;
        uncorr_q <= rx_uncorr;
      end
    end
  end

  assign out_valid_o    = valid_q;
  assign out_class_o    = class_q;
  assign out_syndrome_o = syn_q;
  assign out_data_o     = data_q;
  assign out_uncorr_o   = uncorr_q;

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i |=> out_valid_o);

  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_i |=> !out_valid_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_i |=> ($stable(out_class_o) && $stable(out_syndrome_o) &&
                     $stable(out_data_o) && $stable(out_uncorr_o)));

  // R3
  clean_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ((out_class_o == 2'(CLS_CLEAN)) == (out_syndrome_o == '0)));

  // R4
  single_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_class_o == 2'(CLS_SINGLE)) |->
      (($countones(out_syndrome_o) % 2 == 1) && out_syndrome_o != SYN_MULTI && !out_uncorr_o));

  // R5
  double_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_class_o == 2'(CLS_DOUBLE)) |->
      (($countones(out_syndrome_o) % 2 == 0) && out_syndrome_o != '0 && out_uncorr_o));

  // R6
  multi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_class_o == 2'(CLS_MULTI)) |-> (out_syndrome_o == SYN_MULTI && out_uncorr_o));

  // R5 R6
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_class_o != 2'(CLS_SINGLE)) |->
      (out_data_o == $past(rx_word_i[WORD_W-1 -: DATA_W])));

  // R4
  single_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_class_o == 2'(CLS_SINGLE)) |->
      ($countones(out_data_o ^ $past(rx_word_i[WORD_W-1 -: DATA_W])) <= 1));

  // R4
  flip_sparse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_flip) && (rx_flip == '0 || rx_class == CLS_SINGLE));

  // R3 R4 R5 R6
  decode_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rx_hot) == 1);

endmodule

// File: tb/secded73_codec_tb.sv
module secded73_codec_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] enc_data_i = '0;
  logic [6:0] enc_word_o;
  logic       rx_valid_i = 1'b0;
  logic [6:0] rx_word_i = '0;
  logic       out_valid_o;
  logic [1:0] out_class_o;
  logic [3:0] out_syndrome_o;
  logic [2:0] out_data_o;
  logic       out_uncorr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  secded73_codec u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .enc_data_i     (enc_data_i),
    .enc_word_o     (enc_word_o),
    .rx_valid_i     (rx_valid_i),
    .rx_word_i      (rx_word_i),
    .out_valid_o    (out_valid_o),
    .out_class_o    (out_class_o),
    .out_syndrome_o (out_syndrome_o),
    .out_data_o     (out_data_o),
    .out_uncorr_o   (out_uncorr_o)
  );

  // Bench model: word bits 6..0 = D1 D2 D3 C1 C2 C3 C4
  function automatic logic [6:0] ref_encode(input logic [2:0] d);
    logic a, b, c;
    a = d[2]; b = d[1]; c = d[0];
    return {a, b, c, a ^ c, b ^ c, a ^ b, a ^ b ^ c};
  endfunction

  function automatic logic [3:0] ref_syn(input logic [6:0] w);
    logic [3:0] s;
    s[3] = w[3] ^ w[6] ^ w[4];
    s[2] = w[2] ^ w[5] ^ w[4];
    s[1] = w[1] ^ w[6] ^ w[5];
    s[0] = w[0] ^ w[6] ^ w[5] ^ w[4];
    return s;
  endfunction

  function automatic logic [1:0] ref_class(input logic [3:0] s);
    int wt;
    wt = s[0] + s[1] + s[2] + s[3];
    if (s == 4'b0000) return 2'b00;
    if (s == 4'b1110) return 2'b11;
    if (wt % 2 == 1)  return 2'b01;
    return 2'b10;
  endfunction

  function automatic logic [2:0] ref_data(input logic [6:0] w);
    logic [3:0] s;
    logic [2:0] d;
    s = ref_syn(w);
    d = w[6:4];
    if (s == 4'b1011) d[2] = ~d[2];
    if (s == 4'b0111) d[1] = ~d[1];
    if (s == 4'b1101) d[0] = ~d[0];
    return d;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one word with valid, check registered results one cycle later
  task automatic apply(input logic [6:0] w, input string req);
    logic [3:0] s;
    logic [1:0] c;
    @(negedge clk);
    rx_word_i  = w;
    rx_valid_i = 1'b1;
    @(negedge clk);
    rx_valid_i = 1'b0;
    s = ref_syn(w);
    c = ref_class(s);
    chk(req, "valid", out_valid_o, 1);
    chk("R2", "syndrome", out_syndrome_o, s);
    chk(req, "class", out_class_o, c);
    chk(req, "data", out_data_o, ref_data(w));
    chk(req, "uncorr", out_uncorr_o, (c == 2'b10 || c == 2'b11) ? 1 : 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "valid", out_valid_o, 0);
    chk("R9", "class", out_class_o, 0);
    chk("R9", "syndrome", out_syndrome_o, 0);
    chk("R9", "data", out_data_o, 0);
    chk("R9", "uncorr", out_uncorr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "valid after release", out_valid_o, 0);

    // R1 encoder over all data values
    for (int d = 0; d < 8; d++) begin
      enc_data_i = 3'(d);
      #1;
      chk("R1", "enc_word", enc_word_o, ref_encode(3'(d)));
    end

    // R3, R10 exhaustive clean, single and double on every codeword
    for (int d = 0; d < 8; d++) begin
      logic [6:0] cw;
      cw = ref_encode(3'(d));
      apply(cw, "R3");
      chk("R3", "clean data", out_data_o, d);
      for (int i = 0; i < 7; i++) begin
        apply(cw ^ (7'd1 << i), "R4");
        chk("R10", "single recovered", out_data_o, d);
        chk("R10", "single class", out_class_o, 1);
        for (int j = i + 1; j < 7; j++) begin
          apply(cw ^ (7'd1 << i) ^ (7'd1 << j), "R5");
          chk("R10", "double class", out_class_o, 2);
        end
      end
    end

    // R6 directed: D1 and C2 and C4 flipped on zero word gives 1011^0100^0001 = 1110
    apply(7'b1000101, "R6");
    chk("R6", "multi syndrome", out_syndrome_o, 4'b1110);

    // R8 hold: idle with a different word, outputs must not move
    apply(7'b0010011, "R4");
    @(negedge clk);
    rx_word_i = 7'b1111111;
    rx_valid_i = 1'b0;
    @(negedge clk);
    chk("R7", "valid low on idle", out_valid_o, 0);
    chk("R8", "held syndrome", out_syndrome_o, ref_syn(7'b0010011));
    chk("R8", "held class", out_class_o, ref_class(ref_syn(7'b0010011)));
    chk("R8", "held data", out_data_o, ref_data(7'b0010011));

    // R7 back-to-back words keep strobe high each cycle
    @(negedge clk);
    rx_valid_i = 1'b1;
    rx_word_i  = 7'b0000011;
    @(negedge clk);
    chk("R7", "first b2b valid", out_valid_o, 1);
    chk("R7", "first b2b class", out_class_o, 2);
    rx_word_i = ref_encode(3'd5);
    @(negedge clk);
    rx_valid_i = 1'b0;
    chk("R7", "second b2b valid", out_valid_o, 1);
    chk("R7", "second b2b class", out_class_o, 0);
    @(negedge clk);
    chk("R7", "strobe one cycle", out_valid_o, 0);

    // Random masks of any weight on random codewords
    for (int n = 0; n < 400; n++) begin
      logic [6:0] cw;
      logic [6:0] m;
      cw = ref_encode(3'($urandom));
      m  = 7'($urandom);
      apply(cw ^ m, "R4");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule